// File: doc/BRIEF.md
# Infrared Remote Frame Decoder

This block decodes pulse-distance infrared remote frames from a receiver output that has already been demodulated. On that line the carrier bursts show as low and the quiet gaps as high. The block passes the line through a two-stage synchroniser. It times every low and high interval in units of a tick taken from the system clock. A frame must open with a long low leader and a long high leader. Thirty-two data bits follow, and each bit is a short low mark followed by a high space. A short space gives 0 and a long space gives 1. Each byte arrives low bit first. The four bytes are, in order: the address, its complement, the command, and its complement.

A frame is accepted only if both complement bytes are correct. In that case the address and command go out on a valid/ready output. A frame whose complement bytes are wrong raises a one-cycle error pulse. A leader whose high part is about half the normal length is a repeat code and gives a one-cycle repeat pulse. An interval outside every accepted window ends decoding. When this happens during the data bits it also raises the error pulse.

Back-pressure rules: while `out_valid` is high and `out_ready` is low, `out_addr` and `out_cmd` hold still. A frame that completes during that time is discarded, and the held result is kept. The output is taken on any cycle where both `out_valid` and `out_ready` are high. If no new frame completes in that cycle, `out_valid` falls on the next cycle.

Top module: `ir_frame_rx`

## Requirements
- R1: The line idles high. Decoding starts only after a low of 9 ms ±25% (900 ticks nominal) followed by a high of 4.5 ms ±25% (450 ticks). A short low or any other leader shape returns the block to idle with no error, repeat or output.
- R2: Each data bit is a low mark of 560 µs ±25% (56 ticks) and then a high space. A space of 560 µs ±25% decodes as 0 and a space of 1690 µs ±25% (169 ticks) decodes as 1. Bits fill bytes low bit first. The first byte received is the address and the third is the command.
- R3: After the 32nd bit, `out_valid` rises with `out_addr` and `out_cmd` only if byte 2 equals the bitwise inverse of byte 1 and byte 4 equals the bitwise inverse of byte 3.
- R4: A complete frame that fails either complement check gives exactly one cycle of `err_pulse` and no output.
- R5: A leader low followed by a high of 2.25 ms ±25% (225 ticks) gives exactly one cycle of `rep_pulse`, with no output and no error.
- R6: During the data bits, an interval outside its windows, or a high lasting more than 5 ms (500 ticks), stops decoding and gives one `err_pulse`. The next well-formed frame then decodes normally.
- R7: Frames whose intervals are all stretched or shrunk by 20% decode correctly.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold. A frame that completes in that time is discarded. `out_valid` falls the cycle after a handshake that has no new frame.
- R9: After reset, `out_valid`, `err_pulse` and `rep_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Demodulated receiver line, low during carrier |
| out_valid | output | 1 | Decoded frame available |
| out_ready | input | 1 | Consumer accepts the frame |
| out_addr | output | 8 | Decoded address byte |
| out_cmd | output | 8 | Decoded command byte |
| err_pulse | output | 1 | One cycle: malformed frame or mid-frame timing abort |
| rep_pulse | output | 1 | One cycle: repeat code seen |

## Verification
The assertions check, on every cycle, that the output stays stable under back-pressure. They also check that the error and repeat flags last a single cycle, that a high held too long mid-frame forces idle, that the decoder stays idle until a falling edge, and that every completed or failed frame leaves the decoder idle. Other behaviour depends on whole waveforms, so only the bench scenarios can show it. That covers correct bit order and byte placement under random data and jittered timing, rejection of bad complement bytes, repeat detection, recovery after an abort, the ±20% timing margins, and the dropping of a second frame while the first is still held.

// File: rtl/ir_frame_rx_pkg.sv
package ir_frame_rx_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 4 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_LO,
    ST_LEAD_HI,
    ST_BIT_LO,
    ST_BIT_HI
  } rx_state_e;

  function automatic logic in_window(input int len, input int nom);
    return (len >= nom - nom / 4) && (len <= nom + nom / 4);
  endfunction

  function automatic int win_max(input int nom);
    return nom + nom / 4;
  endfunction
endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_s = sync_q;
  assign rise   = sync_q & ~prev_q;
  assign fall   = ~sync_q & prev_q;
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ir_interval_timer.sv
module ir_interval_timer #(
  parameter int LIMIT = 1200,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          edge_seen,
  output logic [CW-1:0] elapsed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed <= '0;
    else if (edge_seen) elapsed <= '0;
    else if (tick && elapsed != CW'(LIMIT)) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
  import ir_frame_rx_pkg::*;
#(
  parameter int T_LEAD_LO = 900,
  parameter int T_LEAD_HI = 450,
  parameter int T_REP_HI  = 225,
  parameter int T_MARK    = 56,
  parameter int T_ZERO    = 56,
  parameter int T_ONE     = 169,
  parameter int T_ABORT   = 500,
  parameter int CW        = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise,
  input  logic               fall,
  input  logic [CW-1:0]      elapsed,
  output logic               frame_ok,
  output logic               err_pulse,
  output logic               rep_pulse,
  output logic [FRAME_W-1:0] frame_bits
);
  localparam int LL_MAX = win_max(T_LEAD_LO);
  localparam int LH_MAX = win_max(T_LEAD_HI);
  localparam int MK_MAX = win_max(T_MARK);
  localparam int BCW    = $clog2(FRAME_W);

  rx_state_e          state;
  logic [BCW-1:0]     bit_idx;
  logic [FRAME_W-1:0] shift_q;
  logic [FRAME_W-1:0] shift_nx;
  logic               sp_zero, sp_one, frame_good;
  int                 len;

  assign len        = int'(elapsed);
  assign sp_zero    = in_window(len, T_ZERO);
  assign sp_one     = in_window(len, T_ONE);
  assign shift_nx   = {sp_one, shift_q[FRAME_W-1:1]};
  assign frame_good = ((shift_nx[BYTE_W-1:0] ^ shift_nx[2*BYTE_W-1:BYTE_W]) == {BYTE_W{1'b1}}) &&
                      ((shift_nx[3*BYTE_W-1:2*BYTE_W] ^ shift_nx[4*BYTE_W-1:3*BYTE_W]) == {BYTE_W{1'b1}});
  assign frame_bits = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_idx   <= '0;
      shift_q   <= '0;
      frame_ok  <= 1'b0;
      err_pulse <= 1'b0;
      rep_pulse <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      err_pulse <= 1'b0;
      rep_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall) state <= ST_LEAD_LO;
        end
        ST_LEAD_LO: begin
          if (rise) state <= in_window(len, T_LEAD_LO) ? ST_LEAD_HI : ST_IDLE;
          else if (len > LL_MAX) state <= ST_IDLE;
        end
        ST_LEAD_HI: begin
          if (fall) begin
            if (in_window(len, T_LEAD_HI)) begin
              state   <= ST_BIT_LO;
              bit_idx <= '0;
            end else begin
              if (in_window(len, T_REP_HI)) rep_pulse <= 1'b1;
              state <= ST_IDLE;
            end
          end else if (len > LH_MAX) state <= ST_IDLE;
        end
        ST_BIT_LO: begin
          if (rise) begin
            if (in_window(len, T_MARK)) state <= ST_BIT_HI;
            else begin
              state     <= ST_IDLE;
              err_pulse <= 1'b1;
            end
          end else if (len > MK_MAX) begin
            state     <= ST_IDLE;
            err_pulse <= 1'b1;
          end
        end
        ST_BIT_HI: begin
          if (fall) begin
            if (sp_zero || sp_one) begin
              shift_q <= shift_nx;
              if (bit_idx == BCW'(FRAME_W - 1)) begin
                state <= ST_IDLE;
                if (frame_good) frame_ok <= 1'b1;
                else err_pulse <= 1'b1;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                state   <= ST_BIT_LO;
              end
            end else begin
              state     <= ST_IDLE;
              err_pulse <= 1'b1;
            end
          end else if (len > T_ABORT) begin
            state     <= ST_IDLE;
            err_pulse <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !fall) |=> state == ST_IDLE);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || err_pulse) |-> state == ST_IDLE);
  p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  p_rep_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rep_pulse |=> !rep_pulse);
  p_long_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BIT_HI && !fall && len > T_ABORT) |=> state == ST_IDLE);
endmodule

// File: rtl/ir_frame_rx.sv
module ir_frame_rx
  import ir_frame_rx_pkg::*;
#(
  parameter int TICK_DIV  = 1000,
  parameter int T_LEAD_LO = 900,
  parameter int T_LEAD_HI = 450,
  parameter int T_REP_HI  = 225,
  parameter int T_MARK    = 56,
  parameter int T_ZERO    = 56,
  parameter int T_ONE     = 169,
  parameter int T_ABORT   = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_addr,
  output logic [BYTE_W-1:0] out_cmd,
  output logic              err_pulse,
  output logic              rep_pulse
);
  localparam int LL_TOP = win_max(T_LEAD_LO);
  localparam int LIMIT  = ((LL_TOP > T_ABORT) ? LL_TOP : T_ABORT) + 1;
  localparam int CW     = $clog2(LIMIT + 1);

  logic               line_s, rise, fall, tick, frame_ok;
  logic [CW-1:0]      elapsed;
  logic [FRAME_W-1:0] frame_bits;

  ir_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .line_s(line_s), .rise(rise), .fall(fall)
  );

  ir_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ir_interval_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .edge_seen(rise | fall), .elapsed(elapsed)
  );

  ir_frame_fsm #(
    .T_LEAD_LO(T_LEAD_LO), .T_LEAD_HI(T_LEAD_HI), .T_REP_HI(T_REP_HI),
    .T_MARK(T_MARK), .T_ZERO(T_ZERO), .T_ONE(T_ONE), .T_ABORT(T_ABORT), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .elapsed(elapsed),
    .frame_ok(frame_ok), .err_pulse(err_pulse), .rep_pulse(rep_pulse),
    .frame_bits(frame_bits)
  );

  logic unused_line;
  assign unused_line = line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_cmd   <= '0;
    end else if (frame_ok && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_addr  <= frame_bits[BYTE_W-1:0];
      out_cmd   <= frame_bits[3*BYTE_W-1:2*BYTE_W];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_cmd)));
  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frame_ok) |=> !out_valid);
endmodule

// File: tb/ir_frame_rx_bench.sv
module ir_frame_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       out_ready = 1'b1;
  logic       out_valid, err_pulse, rep_pulse;
  logic [7:0] out_addr, out_cmd;

  int n_chk = 0, n_bad = 0;
  int got_n = 0, err_n = 0, rep_n = 0;
  logic [7:0] got_addr = '0, got_cmd = '0;
  bit done = 0;

  always #5 clk = ~clk;

  ir_frame_rx #(.TICK_DIV(1)) u_ir_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_cmd(out_cmd),
    .err_pulse(err_pulse), .rep_pulse(rep_pulse)
  );

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      got_n++;
      got_addr = out_addr;
      got_cmd  = out_cmd;
    end
    if (err_pulse) err_n++;
    if (rep_pulse) rep_n++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int scl(input int nom, input int pct);
    return nom * pct / 100;
  endfunction

  function automatic bit frame_expected_ok(input logic [31:0] w);
    return ((w[7:0] ^ w[15:8]) == 8'hFF) && ((w[23:16] ^ w[31:24]) == 8'hFF);
  endfunction

  task automatic hold(input logic lvl, input int n);
    rx_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] w, input int pct);
    hold(1'b0, scl(900, pct));
    hold(1'b1, scl(450, pct));
    for (int i = 0; i < 32; i++) begin
      hold(1'b0, scl(56, pct));
      hold(1'b1, w[i] ? scl(169, pct) : scl(56, pct));
    end
    hold(1'b0, scl(56, pct));
    hold(1'b1, 60);
  endtask

  task automatic run_good(input string tag, input logic [7:0] a, input logic [7:0] c, input int pct);
    int g0, e0;
    g0 = got_n; e0 = err_n;
    send_frame({~c, c, ~a, a}, pct);
    check({tag, " count"}, got_n - g0, 1);
    check({tag, " addr"}, got_addr, a);
    check({tag, " cmd"}, got_cmd, c);
    check({tag, " no err"}, err_n - e0, 0);
  endtask

  initial begin
    int g0, e0, r0;
    logic [31:0] w;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 out_valid", out_valid, 0);
    check("R9 err_pulse", err_pulse, 0);
    check("R9 rep_pulse", rep_pulse, 0);
    rst_n = 1'b1;
    hold(1'b1, 20);

    // R2 R3 random data with jitter
    for (int k = 0; k < 5; k++) begin
      logic [7:0] a, c;
      a = 8'($urandom); c = 8'($urandom);
      run_good("R2 R3 random", a, c, 90 + int'($urandom_range(0, 20)));
    end
    // R2 bit order corners
    run_good("R2 corner 01/80", 8'h01, 8'h80, 100);
    run_good("R3 corner 00/FF", 8'h00, 8'hFF, 100);

    // R4 bad complement bytes
    g0 = got_n; e0 = err_n;
    w = {8'h12, 8'hED, 8'h5A, 8'h35};
    send_frame(w, 100);
    check("R4 err count", err_n - e0, frame_expected_ok(w) ? 0 : 1);
    check("R4 no output", got_n - g0, 0);

    // R5 repeat code
    g0 = got_n; e0 = err_n; r0 = rep_n;
    hold(1'b0, 900); hold(1'b1, 225); hold(1'b0, 56); hold(1'b1, 100);
    check("R5 rep count", rep_n - r0, 1);
    check("R5 no output", got_n - g0, 0);
    check("R5 no err", err_n - e0, 0);

    // R1 short low glitch and short leader
    g0 = got_n; e0 = err_n; r0 = rep_n;
    hold(1'b0, 30); hold(1'b1, 300);
    hold(1'b0, 500); hold(1'b1, 450); hold(1'b0, 56); hold(1'b1, 600);
    check("R1 glitch no output", got_n - g0, 0);
    check("R1 glitch no err", err_n - e0, 0);
    check("R1 glitch no rep", rep_n - r0, 0);

    // R6 long high mid-frame
    e0 = err_n; g0 = got_n;
    hold(1'b0, 900); hold(1'b1, 450);
    hold(1'b0, 56); hold(1'b1, 169);
    hold(1'b0, 56); hold(1'b1, 800);
    check("R6 timeout err", err_n - e0, 1);
    // R6 space between windows
    e0 = err_n;
    hold(1'b0, 900); hold(1'b1, 450);
    hold(1'b0, 56); hold(1'b1, 350);
    hold(1'b0, 56); hold(1'b1, 700);
    check("R6 window err", err_n - e0, 1);
    check("R6 no output", got_n - g0, 0);
    run_good("R6 recovery", 8'hC3, 8'h3C, 100);

    // R7 tolerance
    run_good("R7 stretch", 8'hA5, 8'h0F, 120);
    run_good("R7 shrink", 8'h5A, 8'hF0, 80);

    // R8 back-pressure
    out_ready = 1'b0;
    send_frame({~8'h22, 8'h22, ~8'h11, 8'h11}, 100);
    check("R8 valid held", out_valid, 1);
    send_frame({~8'h44, 8'h44, ~8'h33, 8'h33}, 100);
    check("R8 still valid", out_valid, 1);
    check("R8 addr kept", out_addr, 8'h11);
    check("R8 cmd kept", out_cmd, 8'h22);
    g0 = got_n;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 taken once", got_n - g0, 1);
    check("R8 valid drops", out_valid, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(negedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule